// File: doc/BRIEF.md
# Selectable Edge-Triggered Launch Conditioner

This block sits in front of a conversion sequencer and decides when a new sequence starts. It picks one of several hardware trigger lines, interprets it with a programmable polarity, and turns the chosen edge into a launch pulse one clock wide in the system clock domain. The selected line can either pass through a flop synchronizer, for lines that are not tied to the system clock, or skip it, for lines that already are, which saves clock cycles between the trigger and the launch.

The polarity bit normalises the line so that its active level reads as 1 inside the block. An edge detector then compares the current level with a history flop. While the block is disabled that history flop is held at the inactive level. As a result, switching the enable on while the chosen line already sits at its active level counts as an edge and produces one launch straight away. While disabled the block never launches.

Top module: `trig_launch_cond`

## Requirements
- R1: Only the line `trigIn[srcSel]` can cause a launch. Activity on any of the other lines has no effect on `launch`.
- R2: With `risingEdge` = 0 a 1-to-0 transition of the selected line launches. With `risingEdge` = 1 a 0-to-1 transition launches. The transition back to the inactive level never launches.
- R3: With `bypassSync` = 1, `launch` is high in the cycle after the first rising clock edge that samples the new level. With `bypassSync` = 0 it comes two clock edges later, at the third edge (default of two synchronizer stages).
- R4: An active level held for a single clock period is detected on both paths.
- R5: If `enable` goes from 0 to 1 while the selected line is already at its active level (and has been there long enough to pass the synchronizer), exactly one launch occurs, in the cycle after the first edge that samples `enable` high.
- R6: `launch` is never high in the cycle after a clock edge that sampled `enable` = 0.
- R7: Each qualifying edge gives exactly one launch, one cycle wide, however long the active level is held.
- R8: During reset (`rstN` = 0, asynchronous) and after it, until a qualifying edge occurs, `launch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | NUM_SRC (8) | Raw hardware trigger lines |
| srcSel | input | SEL_W (3) | Index of the trigger line in use |
| risingEdge | input | 1 | 1: rising edge launches; 0: falling edge launches |
| bypassSync | input | 1 | 1: skip the synchronizer stages |
| enable | input | 1 | Sequence enable; 0 blocks all launches |
| launch | output | 1 | One-cycle launch pulse to the sequencer |

## Verification
The assertions take for granted that the trigger lines change only between clock edges and stay at a level for at least one full clock. They also assume that the source select, polarity and bypass settings are changed only while the block is disabled. Because the assertions rebuild the normalised level from the ports and look back up to four cycles, they are gated until several clocks after reset. The bench drives every input on the falling clock edge and reconfigures only with `enable` low. It waits long enough after each change for the synchronizer to settle, so every latency and count it expects follows from these assumptions.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic armClear;    // hold edge history at the inactive level
    logic fireOk;      // allow a detected edge to reach the output
    logic takeBypass;  // feed the edge detector from the raw level
  } lcStrobes_t;
endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl (
  input  logic              enable,
  input  logic              bypassSync,
  output lc_pkg::lcStrobes_t strb
);
  always_comb begin
    strb.armClear   = !enable;
    strb.fireOk     = enable;
    strb.takeBypass = bypassSync;
  end
endmodule

// File: rtl/lc_datapath.sv
module lc_datapath #(
  parameter int NUM_SRC     = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               risingEdge,
  input  lc_pkg::lcStrobes_t strb,
  output logic               launch
);
  localparam int LAST = SYNC_STAGES - 1;

  logic selRaw;
  logic activeLvl;
  logic [SYNC_STAGES-1:0] syncQ;
  logic pathLvl;
  logic histQ;
  logic edgeSeen;

  // Source multiplexer and polarity normalisation (active reads as 1)
  assign selRaw    = trigIn[srcSel];
  assign activeLvl = risingEdge ? selRaw : !selRaw;

  // Synchronizer chain, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= activeLvl;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign pathLvl  = strb.takeBypass ? activeLvl : syncQ[LAST];
  assign edgeSeen = pathLvl && !histQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ  <= 1'b0;
      launch <= 1'b0;
    end else begin
      histQ  <= strb.armClear ? 1'b0 : pathLvl;
      launch <= edgeSeen && strb.fireOk;
    end
  end
endmodule

// File: rtl/trig_launch_cond.sv
module trig_launch_cond #(
  parameter int NUM_SRC     = 8,
  parameter int SEL_W       = $clog2(NUM_SRC),
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               risingEdge,
  input  logic               bypassSync,
  input  logic               enable,
  output logic               launch
);
  lc_pkg::lcStrobes_t strb;

  lc_ctrl uCtrl (
    .enable     (enable),
    .bypassSync (bypassSync),
    .strb       (strb)
  );

  lc_datapath #(
    .NUM_SRC     (NUM_SRC),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .trigIn     (trigIn),
    .srcSel     (srcSel),
    .risingEdge (risingEdge),
    .strb       (strb),
    .launch     (launch)
  );
endmodule

// File: rtl/trig_launch_cond_chk.sv
module trig_launch_cond_chk #(
  parameter int NUM_SRC     = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] trigIn,
  input logic [SEL_W-1:0]   srcSel,
  input logic               risingEdge,
  input logic               bypassSync,
  input logic               enable,
  input logic               launch
);
  logic lvlNow;
  logic [2:0] age;
  logic warm;

  assign lvlNow = risingEdge ? trigIn[srcSel] : !trigIn[srcSel];
  assign warm   = (age >= 3'd5);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= 3'd0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R6: no launch after an edge that saw the block disabled
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    warm && !$past(enable) |-> !launch);

  // R7: a launch is one cycle wide
  assert_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !launch);

  // R3 / R2 / R1: bypass path follows the selected level with one edge
  assert_bypass_lat_R3: assert property (@(posedge clk) disable iff (!rstN)
    warm && $past(enable) && $past(enable, 2) && $past(bypassSync) && $past(bypassSync, 2)
    |-> launch == ($past(lvlNow) && !$past(lvlNow, 2)));

  // R5: arming on the bypass path reports the present level
  assert_arm_byp_R5: assert property (@(posedge clk) disable iff (!rstN)
    warm && $past(enable) && !$past(enable, 2) && $past(bypassSync)
    |-> launch == $past(lvlNow));

  if (SYNC_STAGES == 2) begin : gSyncTwo
    // R3: synchronized path adds two edges of latency
    assert_sync_lat_R3: assert property (@(posedge clk) disable iff (!rstN)
      warm && $past(enable) && $past(enable, 2) && !$past(bypassSync) && !$past(bypassSync, 2)
      |-> launch == ($past(lvlNow, 3) && !$past(lvlNow, 4)));

    // R5: arming on the synchronized path reports the synchronized level
    assert_arm_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
      warm && $past(enable) && !$past(enable, 2) && !$past(bypassSync)
      |-> launch == $past(lvlNow, 3));
  end
endmodule

bind trig_launch_cond trig_launch_cond_chk #(
  .NUM_SRC     (NUM_SRC),
  .SEL_W       (SEL_W),
  .SYNC_STAGES (SYNC_STAGES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .trigIn     (trigIn),
  .srcSel     (srcSel),
  .risingEdge (risingEdge),
  .bypassSync (bypassSync),
  .enable     (enable),
  .launch     (launch)
);

// File: tb/trig_launch_cond_test.sv
`timescale 1ns/1ps
module trig_launch_cond_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] trigIn;
  logic [2:0] srcSel;
  logic       risingEdge;
  logic       bypassSync;
  logic       enable;
  logic       launch;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_launch_cond uut (
    .clk        (clk),
    .rstN       (rstN),
    .trigIn     (trigIn),
    .srcSel     (srcSel),
    .risingEdge (risingEdge),
    .bypassSync (bypassSync),
    .enable     (enable),
    .launch     (launch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count launches over a window; optionally drive the selected line inactive after cycle rel
  task automatic measure(input int win, input int rel, output int cnt, output int first);
    cnt = 0;
    first = -1;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (launch) begin
        cnt++;
        if (first < 0) first = i;
      end
      if (i == rel) trigIn[srcSel] = !risingEdge;
    end
  endtask

  task automatic runCase(input int src, input bit pol, input bit byp);
    int cnt, first, lat;
    logic [7:0] idleAll;
    lat = byp ? 1 : 3;
    idleAll = pol ? 8'h00 : 8'hFF;
    enable = 1'b0;
    srcSel = src[2:0];
    risingEdge = pol;
    bypassSync = byp;
    trigIn = idleAll;
    waitCycles(5);

    // R5: arming with the line inactive gives nothing
    enable = 1'b1;
    measure(6, 0, cnt, first);
    check(cnt == 0, "R5 arm idle", cnt, 0);

    // R1: the other lines are ignored
    trigIn = ~idleAll;
    trigIn[srcSel] = !pol;
    measure(8, 2, cnt, first);
    trigIn = idleAll;
    check(cnt == 0, "R1 other lines", cnt, 0);

    // R4 / R3: one-cycle pulse, latency per path
    trigIn[srcSel] = pol;
    measure(8, 1, cnt, first);
    check(cnt == 1, "R4 short pulse count", cnt, 1);
    check(first == lat, "R3 latency", first, lat);

    // R7: held level gives one launch; R2: return edge gives none
    trigIn[srcSel] = pol;
    measure(8, 0, cnt, first);
    check(cnt == 1 && first == lat, "R7 held level", cnt, 1);
    trigIn[srcSel] = !pol;
    measure(8, 0, cnt, first);
    check(cnt == 0, "R2 inactive edge", cnt, 0);

    // R6: disabled, pulses never launch
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      trigIn[srcSel] = pol;
      measure(6, 1, cnt, first);
      check(cnt == 0, "R6 disabled pulse", cnt, 0);
    end

    // R5: arming with the line already active
    trigIn[srcSel] = pol;
    waitCycles(5);
    enable = 1'b1;
    measure(8, 0, cnt, first);
    check(cnt == 1 && first == 1, "R5 immediate launch", first, 1);
    enable = 1'b0;
    trigIn[srcSel] = !pol;
    waitCycles(4);
  endtask

  initial begin
    rstN = 1'b0;
    trigIn = 8'h00;
    srcSel = 3'd0;
    risingEdge = 1'b1;
    bypassSync = 1'b0;
    enable = 1'b0;
    waitCycles(2);
    check(launch == 1'b0, "R8 reset value", launch, 0);
    enable = 1'b1;
    trigIn = 8'hFF;
    waitCycles(2);
    check(launch == 1'b0, "R8 held in reset", launch, 0);
    enable = 1'b0;
    trigIn = 8'h00;
    rstN = 1'b1;
    waitCycles(4);
    check(launch == 1'b0, "R8 after reset", launch, 0);

    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 2; p++)
        for (int b = 0; b < 2; b++)
          runCase(s, p[0], b[0]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule